// File: doc/BRIEF.md
# Load-Bypassing Store Parking Unit

This unit arbitrates a single-ported local data memory between a pipelined core whose loads issue from decode and whose stores issue one stage later from execute. When an execute-stage store and a younger decode-stage load reach the port in the same cycle, the store is parked in a one-entry holding register and the load uses the port first. The parked store is written back on a later cycle that either carries another store or has no memory access at all.

Because a load may now read memory ahead of an older store, the unit compares the load's byte range against the parked store's byte enables, and against the store arriving in the same cycle. On any shared byte, the load is refused with a retry, the store is written in that cycle, and the core presents the load again in the next cycle. Stores aimed at bus-attached memory never park and take the port in the cycle they arrive. When address translation is on and either side carries a translated address, only the low ten address bits take part in the comparison.

The core is expected to re-present a refused load unchanged in the following cycle. Stores are never refused.

Top module: `sbuf_bypass_top`

## Requirements
- R1: After reset, with no requests, the port is idle (`mem_req`=0, all port fields 0) and `ld_retry` is 0. No write-back appears, so the holding register is empty.
- R2: A local store together with a non-overlapping load, with the holding register empty, gives the port to the load in that cycle: `mem_we`=0, `mem_local`=1, `mem_addr`=load address, `mem_size`=load size, `mem_be`=0, `mem_wdata`=0, and no retry. The store is parked.
- R3: A parked store is written on the first cycle with no request at all. The port then shows `mem_we`=1, `mem_local`=1, `mem_size`=3, and the parked doubleword-aligned address, data and byte enables. The following empty cycle is idle.
- R4: A local store arriving while the holding register is full writes the old entry on the port in that cycle and parks the new store in its place. A load presented in that cycle is retried.
- R5: A local store with no load and an empty holding register is written on the port in the same cycle. Nothing is parked.
- R6: A store with `st_local`=0 takes the port in its own cycle with `mem_local`=0. A load in that cycle is retried, and a parked entry is kept for a later write-back.
- R7: A load that shares no byte with the parked entry is granted the port, and the entry stays parked.
- R8: A load sharing at least one byte with the parked entry is refused with `ld_retry`=1, and the entry is written in that cycle. The re-presented load is granted in the next cycle with `ld_retry`=0. This applies to partial overlap and to loads that cross a doubleword boundary.
- R9: A load that shares a byte with the local store arriving in the same cycle, with the holding register empty, makes the store write at once. The load is retried.
- R10: With `xlat_en`=1 and either the load or the parked entry marked translated, the overlap test compares only address bits 9..0. Otherwise it compares the full address.
- R11: `ld_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes starting at `ld_addr`, which may be unaligned. Store addresses are doubleword addresses: bits 2..0 are ignored, and `st_be` bit i selects byte i of that doubleword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xlat_en | input | 1 | Address translation enabled |
| ld_req | input | 1 | Load request from decode stage |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | 2 | Load size code (0:1, 1:2, 2:4, 3:8 bytes) |
| ld_xlat | input | 1 | Load address is translated |
| st_req | input | 1 | Store request from execute stage |
| st_addr | input | ADDR_W | Store doubleword address (low 3 bits ignored) |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_local | input | 1 | 1: local memory target, 0: bus memory target |
| st_xlat | input | 1 | Store address is translated |
| ld_retry | output | 1 | Load refused this cycle; re-present next cycle |
| mem_req | output | 1 | Port access this cycle |
| mem_we | output | 1 | Port access is a write |
| mem_local | output | 1 | Access goes to local memory |
| mem_addr | output | ADDR_W | Access address |
| mem_size | output | 2 | Access size code |
| mem_be | output | DATA_W/8 | Write byte enables |
| mem_wdata | output | DATA_W | Write data |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, eight byte lanes and a ten-bit compare window under translation. Eight lanes let 4- and 8-byte loads start at unaligned offsets and run into the next doubleword, which exercises the upper half of the byte-span mask. Addresses 0x1100 and 0x5100 share bits 9..0 but differ above them. This pair shows a false conflict when translation is on, and no conflict when translation is off.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } ld_size_e;

  typedef enum logic [1:0] {
    PORT_IDLE  = 2'd0,
    PORT_LOAD  = 2'd1,
    PORT_DRAIN = 2'd2,
    PORT_STNEW = 2'd3
  } port_sel_e;

endpackage

// File: rtl/sbuf_overlap.sv
module sbuf_overlap #(
  parameter int AW       = 32,
  parameter int LANES    = 8,
  parameter int CMP_BITS = 10,
  localparam int OFFW    = $clog2(LANES),
  localparam int WAW     = AW - OFFW
) (
  input  logic [AW-1:0]    ld_addr,
  input  logic [1:0]       ld_size,
  input  logic [WAW-1:0]   st_word,
  input  logic [LANES-1:0] st_be,
  input  logic             low_only,
  output logic             hit
);
  localparam int KW = CMP_BITS - OFFW;

  logic [LANES-1:0]   len_mask;
  logic [2*LANES-1:0] span;
  logic [WAW-1:0]     lw0, lw1;
  logic               eq0, eq1;

  // byte mask of the load, spread across two adjacent doublewords
  always_comb begin
    for (int i = 0; i < LANES; i++)
      len_mask[i] = (i < int'(32'd1 << ld_size));
    span = {{LANES{1'b0}}, len_mask} << ld_addr[OFFW-1:0];
  end

  always_comb begin
    lw0 = ld_addr[AW-1:OFFW];
    lw1 = lw0 + WAW'(1);
    if (low_only) begin
      eq0 = (lw0[KW-1:0] == st_word[KW-1:0]);
      eq1 = (lw1[KW-1:0] == st_word[KW-1:0]);
    end else begin
      eq0 = (lw0 == st_word);
      eq1 = (lw1 == st_word);
    end
    hit = (eq0 && |(span[LANES-1:0] & st_be)) ||
          (eq1 && |(span[2*LANES-1:LANES] & st_be));
  end

endmodule

// File: rtl/sbuf_entry.sv
module sbuf_entry #(
  parameter int WAW   = 29,
  parameter int DW    = 64,
  parameter int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             park,
  input  logic             clear,
  input  logic [WAW-1:0]   d_word,
  input  logic [DW-1:0]    d_data,
  input  logic [LANES-1:0] d_be,
  input  logic             d_xlat,
  output logic             q_valid,
  output logic [WAW-1:0]   q_word,
  output logic [DW-1:0]    q_data,
  output logic [LANES-1:0] q_be,
  output logic             q_xlat
);
  logic valid_nxt;

  always_comb begin
    valid_nxt = q_valid;
    if (clear) valid_nxt = 1'b0;
    if (park)  valid_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_valid <= 1'b0;
    else        q_valid <= valid_nxt;
  end

  // payload: clock-enabled by park, no reset needed
  always_ff @(posedge clk) begin
    if (park) begin
      q_word <= d_word;
      q_data <= d_data;
      q_be   <= d_be;
      q_xlat <= d_xlat;
    end
  end

endmodule

// File: rtl/sbuf_arb.sv
module sbuf_arb
  import sbuf_pkg::*;
(
  input  logic      ld_req,
  input  logic      st_req,
  input  logic      st_local,
  input  logic      sb_valid,
  input  logic      hit_buf,
  input  logic      hit_new,
  output port_sel_e sel,
  output logic      retry,
  output logic      park,
  output logic      clear
);
  always_comb begin
    sel   = PORT_IDLE;
    retry = 1'b0;
    park  = 1'b0;
    clear = 1'b0;
    if (st_req && !st_local) begin
      sel   = PORT_STNEW;          // bus store: in order, right now
      retry = ld_req;
    end else if (st_req) begin
      if (sb_valid) begin
        sel   = PORT_DRAIN;        // old entry out, new one in
        park  = 1'b1;
        retry = ld_req;
      end else if (ld_req && !hit_new) begin
        sel  = PORT_LOAD;          // load overtakes, store parks
        park = 1'b1;
      end else begin
        sel   = PORT_STNEW;
        retry = ld_req;
      end
    end else if (ld_req) begin
      if (sb_valid && hit_buf) begin
        sel   = PORT_DRAIN;
        clear = 1'b1;
        retry = 1'b1;
      end else begin
        sel = PORT_LOAD;
      end
    end else if (sb_valid) begin
      sel   = PORT_DRAIN;
      clear = 1'b1;
    end
  end

endmodule

// File: rtl/sbuf_bypass_top.sv
module sbuf_bypass_top
  import sbuf_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 64,
  parameter int XLAT_CMP = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xlat_en,
  input  logic                  ld_req,
  input  logic [ADDR_W-1:0]     ld_addr,
  input  logic [1:0]            ld_size,
  input  logic                  ld_xlat,
  input  logic                  st_req,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic [DATA_W-1:0]     st_data,
  input  logic [DATA_W/8-1:0]   st_be,
  input  logic                  st_local,
  input  logic                  st_xlat,
  output logic                  ld_retry,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic                  mem_local,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [1:0]            mem_size,
  output logic [DATA_W/8-1:0]   mem_be,
  output logic [DATA_W-1:0]     mem_wdata
);
  localparam int LANES = DATA_W / 8;
  localparam int OFFW  = $clog2(LANES);
  localparam int WAW   = ADDR_W - OFFW;

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_q  <= rst_s1;
    end
  end

  logic             sb_valid, sb_xlat;
  logic [WAW-1:0]   sb_word;
  logic [DATA_W-1:0] sb_data;
  logic [LANES-1:0] sb_be;
  logic             park, clear;
  port_sel_e        sel;

  logic [WAW-1:0]   st_word;
  assign st_word = st_addr[ADDR_W-1:OFFW];

  // overlap against two sources: 0 = parked entry, 1 = arriving store
  logic [WAW-1:0]   cmp_word [2];
  logic [LANES-1:0] cmp_be   [2];
  logic             cmp_low  [2];
  logic             cmp_hit  [2];

  assign cmp_word[0] = sb_word;
  assign cmp_be[0]   = sb_be;
  assign cmp_low[0]  = xlat_en && (ld_xlat || sb_xlat);
  assign cmp_word[1] = st_word;
  assign cmp_be[1]   = st_be;
  assign cmp_low[1]  = xlat_en && (ld_xlat || st_xlat);

  for (genvar g = 0; g < 2; g++) begin : g_ovl
    sbuf_overlap #(
      .AW(ADDR_W), .LANES(LANES), .CMP_BITS(XLAT_CMP)
    ) i_ovl (
      .ld_addr (ld_addr),
      .ld_size (ld_size),
      .st_word (cmp_word[g]),
      .st_be   (cmp_be[g]),
      .low_only(cmp_low[g]),
      .hit     (cmp_hit[g])
    );
  end

  sbuf_arb i_arb (
    .ld_req  (ld_req),
    .st_req  (st_req),
    .st_local(st_local),
    .sb_valid(sb_valid),
    .hit_buf (cmp_hit[0]),
    .hit_new (cmp_hit[1]),
    .sel     (sel),
    .retry   (ld_retry),
    .park    (park),
    .clear   (clear)
  );

  sbuf_entry #(.WAW(WAW), .DW(DATA_W), .LANES(LANES)) i_entry (
    .clk    (clk),
    .rst_n  (rst_q),
    .park   (park),
    .clear  (clear),
    .d_word (st_word),
    .d_data (st_data),
    .d_be   (st_be),
    .d_xlat (st_xlat),
    .q_valid(sb_valid),
    .q_word (sb_word),
    .q_data (sb_data),
    .q_be   (sb_be),
    .q_xlat (sb_xlat)
  );

  // port multiplexer
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_local = 1'b0;
    mem_addr  = '0;
    mem_size  = 2'd0;
    mem_be    = '0;
    mem_wdata = '0;
    unique case (sel)
      PORT_LOAD: begin
        mem_req   = 1'b1;
        mem_local = 1'b1;
        mem_addr  = ld_addr;
        mem_size  = ld_size;
      end
      PORT_DRAIN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_local = 1'b1;
        mem_addr  = {sb_word, {OFFW{1'b0}}};
        mem_size  = SZ_DWORD;
        mem_be    = sb_be;
        mem_wdata = sb_data;
      end
      PORT_STNEW: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_local = st_local;
        mem_addr  = {st_word, {OFFW{1'b0}}};
        mem_size  = SZ_DWORD;
        mem_be    = st_be;
        mem_wdata = st_data;
      end
      default: ;
    endcase
  end

  // ---------------- assertions ----------------
  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_q)
    (!ld_req && !st_req && !sb_valid) |-> (!mem_req && !ld_retry));

  p_store_parks_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (st_req && st_local && ld_req && !ld_retry) |=> sb_valid);

  p_idle_drains_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (sb_valid && !st_req && !ld_req) |=> !sb_valid);

  p_full_refills_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (sb_valid && st_req && st_local) |=> sb_valid);

  p_bus_now_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (st_req && !st_local) |-> (mem_req && mem_we && !mem_local));

  p_bus_keeps_entry_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (st_req && !st_local && sb_valid) |=> sb_valid);

  p_no_load_on_retry_r8: assert property (@(posedge clk) disable iff (!rst_q)
    ld_retry |-> !(mem_req && !mem_we));

  p_conflict_empties_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (ld_retry && !st_req) |=> !sb_valid);

endmodule

// File: tb/test_sbuf_bypass_top.sv
module test_sbuf_bypass_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        xlat_en, ld_req, ld_xlat, st_req, st_local, st_xlat;
  logic [31:0] ld_addr, st_addr;
  logic [1:0]  ld_size;
  logic [63:0] st_data;
  logic [7:0]  st_be;
  logic        ld_retry, mem_req, mem_we, mem_local;
  logic [31:0] mem_addr;
  logic [1:0]  mem_size;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  sbuf_bypass_top i_sbuf_bypass_top (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en),
    .ld_req(ld_req), .ld_addr(ld_addr), .ld_size(ld_size), .ld_xlat(ld_xlat),
    .st_req(st_req), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .st_local(st_local), .st_xlat(st_xlat),
    .ld_retry(ld_retry), .mem_req(mem_req), .mem_we(mem_we),
    .mem_local(mem_local), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_be(mem_be), .mem_wdata(mem_wdata)
  );

  task automatic drive(input bit lr, input logic [31:0] la, input logic [1:0] ls,
                       input bit lx, input bit sr, input logic [31:0] sa,
                       input logic [63:0] sd, input logic [7:0] sbe,
                       input bit sl, input bit sx, input bit xe);
    ld_req = lr; ld_addr = la; ld_size = ls; ld_xlat = lx;
    st_req = sr; st_addr = sa; st_data = sd; st_be = sbe;
    st_local = sl; st_xlat = sx; xlat_en = xe;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic ld_only(input logic [31:0] la, input logic [1:0] ls);
    drive(1, la, ls, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // check full port tuple mid-cycle, then advance to next negedge
  task automatic expect_port(input string tag, input bit req, input bit we,
                             input bit loc, input logic [31:0] a,
                             input logic [1:0] sz, input logic [7:0] be,
                             input logic [63:0] d, input bit rt);
    logic [109:0] act, exp;
    #5;
    act = {mem_req, mem_we, mem_local, mem_addr, mem_size, mem_be, mem_wdata, ld_retry};
    exp = {req, we, loc, a, sz, be, d, rt};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act req=%b we=%b loc=%b addr=%h sz=%0d be=%h d=%h retry=%b exp req=%b we=%b loc=%b addr=%h sz=%0d be=%h d=%h retry=%b",
               tag, mem_req, mem_we, mem_local, mem_addr, mem_size, mem_be, mem_wdata,
               ld_retry, req, we, loc, a, sz, be, d, rt);
    end
    @(negedge clk);
  endtask

  task automatic exp_load(input string tag, input logic [31:0] a, input logic [1:0] sz);
    expect_port(tag, 1, 0, 1, a, sz, 8'h00, 64'h0, 0);
  endtask

  task automatic exp_write(input string tag, input bit loc, input logic [31:0] a,
                           input logic [7:0] be, input logic [63:0] d, input bit rt);
    expect_port(tag, 1, 1, loc, a, 2'd3, be, d, rt);
  endtask

  task automatic exp_idle(input string tag);
    expect_port(tag, 0, 0, 0, 0, 0, 8'h00, 64'h0, 0);
  endtask

  // park a local store at sa while an unrelated load takes the port
  task automatic park(input logic [31:0] sa, input logic [63:0] sd,
                      input logic [7:0] sbe, input logic [31:0] la);
    drive(1, la, 2'd0, 0, 1, sa, sd, sbe, 1, 0, 0);
    exp_load("R2 park with load", la, 2'd0);
  endtask

  task automatic t_reset();
    idle();
    exp_idle("R1 idle after reset");
    exp_idle("R1 still idle");
  endtask

  task automatic t_park_drain();
    drive(1, 32'h200, 2'd2, 0, 1, 32'h100, 64'h1111_2222_3333_4444, 8'h0F, 1, 0, 0);
    exp_load("R2 load overtakes store", 32'h200, 2'd2);
    idle();
    exp_write("R3 drain on free cycle", 1, 32'h100, 8'h0F, 64'h1111_2222_3333_4444, 0);
    exp_idle("R3 empty after drain");
  endtask

  task automatic t_direct();
    drive(0, 0, 0, 0, 1, 32'h10D, 64'hA5A5_0000_FFFF_0001, 8'hFF, 1, 0, 0);
    exp_write("R5 direct store, R11 low bits ignored", 1, 32'h108, 8'hFF,
              64'hA5A5_0000_FFFF_0001, 0);
    idle();
    exp_idle("R5 nothing parked");
  endtask

  task automatic t_full();
    park(32'h100, 64'hAAAA, 8'h03, 32'h300);
    drive(1, 32'h400, 2'd1, 0, 1, 32'h140, 64'hBBBB, 8'h0C, 1, 0, 0);
    exp_write("R4 old entry out, load retried", 1, 32'h100, 8'h03, 64'hAAAA, 1);
    ld_only(32'h400, 2'd1);
    exp_load("R4 reissued load granted", 32'h400, 2'd1);
    idle();
    exp_write("R4 new entry drains", 1, 32'h140, 8'h0C, 64'hBBBB, 0);
    park(32'h180, 64'hC1, 8'h01, 32'h300);
    drive(0, 0, 0, 0, 1, 32'h1C0, 64'hC2, 8'h02, 1, 0, 0);
    exp_write("R4 store-only swaps entry", 1, 32'h180, 8'h01, 64'hC1, 0);
    idle();
    exp_write("R4 swapped entry drains", 1, 32'h1C0, 8'h02, 64'hC2, 0);
    exp_idle("R4 empty");
  endtask

  task automatic t_bus();
    park(32'h100, 64'hD00D, 8'hF0, 32'h300);
    drive(1, 32'h500, 2'd0, 0, 1, 32'h8000, 64'hBEEF, 8'hFF, 0, 0, 0);
    exp_write("R6 bus store now, load retried", 0, 32'h8000, 8'hFF, 64'hBEEF, 1);
    ld_only(32'h500, 2'd0);
    exp_load("R6 load after bus store", 32'h500, 2'd0);
    idle();
    exp_write("R6 parked entry kept", 1, 32'h100, 8'hF0, 64'hD00D, 0);
  endtask

  task automatic t_conflict();
    // partial overlap: store byte 0x107, load 0x106..0x109
    park(32'h100, 64'h77, 8'h80, 32'h300);
    ld_only(32'h106, 2'd2);
    exp_write("R8 conflict drains", 1, 32'h100, 8'h80, 64'h77, 1);
    ld_only(32'h106, 2'd2);
    exp_load("R8 replay granted", 32'h106, 2'd2);
    // boundary crossing: store byte 0x108, load 0x104..0x10B
    park(32'h108, 64'h88, 8'h01, 32'h300);
    ld_only(32'h104, 2'd3);
    exp_write("R11 crossing load conflicts", 1, 32'h108, 8'h01, 64'h88, 1);
    ld_only(32'h104, 2'd3);
    exp_load("R11 crossing replay", 32'h104, 2'd3);
    // adjacent, no overlap: store 0x100..0x103, load 0x104..0x107
    park(32'h100, 64'h99, 8'h0F, 32'h300);
    ld_only(32'h104, 2'd2);
    exp_load("R7 disjoint load granted", 32'h104, 2'd2);
    ld_only(32'h103, 2'd0);
    exp_write("R11 single byte conflict", 1, 32'h100, 8'h0F, 64'h99, 1);
    idle();
    exp_idle("R8 nothing left");
  endtask

  task automatic t_same_cycle();
    drive(1, 32'h202, 2'd1, 0, 1, 32'h200, 64'h55, 8'h0F, 1, 0, 0);
    exp_write("R9 store written, load retried", 1, 32'h200, 8'h0F, 64'h55, 1);
    ld_only(32'h202, 2'd1);
    exp_load("R9 replay granted", 32'h202, 2'd1);
    idle();
    exp_idle("R9 nothing parked");
  endtask

  task automatic t_xlat();
    park(32'h1100, 64'h66, 8'h01, 32'h3000);
    drive(1, 32'h5100, 2'd0, 1, 0, 0, 0, 0, 0, 0, 1);
    exp_write("R10 alias conflict with translation", 1, 32'h1100, 8'h01, 64'h66, 1);
    drive(1, 32'h5100, 2'd0, 1, 0, 0, 0, 0, 0, 0, 1);
    exp_load("R10 alias replay", 32'h5100, 2'd0);
    park(32'h1100, 64'h67, 8'h01, 32'h3000);
    drive(1, 32'h5100, 2'd0, 1, 0, 0, 0, 0, 0, 0, 0);
    exp_load("R10 full compare when disabled", 32'h5100, 2'd0);
    drive(1, 32'h5100, 2'd0, 0, 0, 0, 0, 0, 0, 0, 1);
    exp_load("R10 full compare when untranslated", 32'h5100, 2'd0);
    idle();
    exp_write("R10 entry drains", 1, 32'h1100, 8'h01, 64'h67, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_park_drain();
    t_direct();
    t_full();
    t_bus();
    t_conflict();
    t_same_cycle();
    t_xlat();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule